// File: doc/BRIEF.md
# Radiation-Tolerant Pixel Configuration Column

This block holds the configuration of one column of a pixel array. Every pixel owns eight configuration bits. Each bit is kept as three identical copies, and a bitwise two-of-three vote over the copies drives the parallel configuration outputs. A single upset copy is therefore outvoted and never reaches the pixel. On every clock, any copy that disagrees with the vote is written back with the voted value. A lone upset therefore lives for at most one cycle.

Data never goes straight into the protected copies. It is shifted serially into a plain flip-flop staging chain, and a load strobe then copies the whole chain into all three copies in one clock. A readback strobe does the reverse: it captures the voted contents into the chain. The chain is then shifted out serially, so software can compare what is stored with what was sent. The staging flops are the weaker element and are never the stored state. A one-cycle error pulse reports that some cell held a disagreeing copy.

Top module: `pixcfg_column`

## Requirements
- R1: A synchronous active-high reset clears the staging chain, all three copies of every cell and the error flag, so `cfg_out`, `sout` and `err` read 0 one cycle later.
- R2: While `shift_en` is high, the chain advances one place per clock. `sin` enters bit 0, and `sout` always shows the top bit (index CELLS-1). After CELLS shifts, the bit shifted in first sits at the top.
- R3: A `load` pulse writes the whole chain into all three copies of every cell in one clock. `cfg_out` shows the chain one cycle later. Pixel p, bit k appears at `cfg_out[p*8+k]`.
- R4: Without `load`, shifting or reading back does not change `cfg_out`.
- R5: When one of the three copies of a bit is upset, `cfg_out` keeps the majority value.
- R6: A disagreeing copy is rewritten with the voted value at the next clock. A later upset of a different copy of the same bit is then also outvoted.
- R7: `err` is high for exactly the one cycle after a clock edge at which some cell had a disagreeing copy, and low otherwise.
- R8: A `readback` pulse loads the voted value of every cell into the chain. Shifting then delivers it on `sout` highest index first, that is pixel NPIX-1 bit 7 first and pixel 0 bit 0 last.
- R9: `readback` takes priority over `shift_en` for the chain. A `load` in the same cycle as a shift stores the chain contents from before that shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift and storage clock |
| rst | input | 1 | Synchronous active-high reset |
| sin | input | 1 | Serial data into the chain |
| shift_en | input | 1 | Advance the chain by one place |
| load | input | 1 | Copy the chain into all copies |
| readback | input | 1 | Capture voted values into the chain |
| sout | output | 1 | Top bit of the chain |
| cfg_out | output | NPIX*BITS | Voted configuration, pixel p bit k at p*BITS+k |
| err | output | 1 | One-cycle pulse after a copy disagreement |

## Verification
A wrong value in one copy never shows on `cfg_out` by itself. It shows as an `err` pulse one cycle later. If scrubbing is broken, it shows as a flipped output bit once a second copy of the same bit is upset. The bench injects single and sequential upsets and checks both effects within two cycles. A wrong staging or readback order shows as a permuted serial stream on `sout`. Every readback is therefore compared bit by bit, and every load is checked by reading `cfg_out` one cycle after the strobe.

// File: rtl/pixcfg_column.sv
module pixcfg_column #(
  parameter int NPIX = 32,
  parameter int BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sin,
  input  logic                 shift_en,
  input  logic                 load,
  input  logic                 readback,
  output logic                 sout,
  output logic [NPIX*BITS-1:0] cfg_out,
  output logic                 err
);
  localparam int CELLS = NPIX * BITS;

  logic [CELLS-1:0] chain;
  logic [CELLS-1:0] copy_a, copy_b, copy_c;
  logic [CELLS-1:0] voted, mismatch;

  assign voted    = (copy_a & copy_b) | (copy_a & copy_c) | (copy_b & copy_c);
  assign mismatch = (copy_a ^ copy_b) | (copy_b ^ copy_c);
  assign cfg_out  = voted;
  assign sout     = chain[CELLS-1];

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else if (readback) chain <= voted;
    else if (shift_en) chain <= {chain[CELLS-2:0], sin};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      copy_a <= '0;
      copy_b <= '0;
      copy_c <= '0;
    end else if (load) begin
      copy_a <= chain;
      copy_b <= chain;
      copy_c <= chain;
    end else begin
      copy_a <= voted;
      copy_b <= voted;
      copy_c <= voted;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else err <= |mismatch;
  end

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (chain == '0 && cfg_out == '0 && !err));

  p_shift_moves_r2: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !readback) |=> sout == $past(chain[CELLS-2]));

  p_load_copies_r3: assert property (@(posedge clk) disable iff (rst)
    load |=> cfg_out == $past(chain));

  p_hold_without_load_r4: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(cfg_out));

  p_flag_after_scrub_r7: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(!load) |-> (copy_a == copy_b || copy_b == copy_c || copy_a == copy_c));

  p_readback_capture_r8: assert property (@(posedge clk) disable iff (rst)
    readback |=> chain == $past(voted));
endmodule

// File: tb/pixcfg_column_test.sv
module pixcfg_column_test;
  localparam int NPIX = 32;
  localparam int BITS = 8;
  localparam int CELLS = NPIX * BITS;

  logic clk = 0, rst = 1, sin = 0, shift_en = 0, load = 0, readback = 0;
  logic sout, err;
  logic [CELLS-1:0] cfg_out;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [CELLS-1:0] exp_cfg;

  pixcfg_column #(.NPIX(NPIX), .BITS(BITS)) uut (
    .clk(clk), .rst(rst), .sin(sin), .shift_en(shift_en), .load(load),
    .readback(readback), .sout(sout), .cfg_out(cfg_out), .err(err));

  always #10 clk = ~clk;

  function automatic logic [CELLS-1:0] rand_vec();
    logic [CELLS-1:0] v;
    for (int w = 0; w < CELLS / 32; w++) v[w*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic int cell_index(int pix, int bitn);
    return pix * BITS + bitn;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string act, input string expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %s expected %s", req, act, expv);
    end
  endtask

  task automatic shift_vec(input logic [CELLS-1:0] v);
    for (int i = CELLS - 1; i >= 0; i--) begin
      sin = v[i];
      shift_en = 1;
      step();
    end
    shift_en = 0;
    sin = 0;
  endtask

  task automatic do_load();
    load = 1;
    step();
    load = 0;
  endtask

  task automatic read_and_check(input logic [CELLS-1:0] expv, input string req);
    int bad = 0;
    int first = -1;
    readback = 1;
    step();
    readback = 0;
    for (int i = CELLS - 1; i >= 0; i--) begin
      if (sout !== expv[i]) begin
        bad++;
        if (first < 0) first = i;
      end
      shift_en = 1;
      step();
    end
    shift_en = 0;
    chk(bad == 0, req, $sformatf("%0d wrong bits, first at %0d", bad, first), "0 wrong bits");
  endtask

  task automatic flip(input int which, input int idx);
    case (which)
      0: uut.copy_a[idx] = ~uut.copy_a[idx];
      1: uut.copy_b[idx] = ~uut.copy_b[idx];
      default: uut.copy_c[idx] = ~uut.copy_c[idx];
    endcase
  endtask

  initial begin
    logic [CELLS-1:0] v;
    int idx, which;
    void'($urandom(32'd12345));
    @(negedge clk);
    step();
    step();
    rst = 0;
    chk(cfg_out == '0 && !err && !sout, "R1", $sformatf("cfg %h err %b", cfg_out, err), "all zero");

    v = '0;
    v[cell_index(NPIX - 1, BITS - 1)] = 1'b1;
    v[cell_index(0, 0)] = 1'b1;
    v[cell_index(5, 3)] = 1'b1;
    shift_vec(v);
    chk(sout == 1'b1, "R2", $sformatf("%b", sout), "1");
    chk(cfg_out == '0, "R4", $sformatf("%h", cfg_out), "0");
    do_load();
    exp_cfg = v;
    chk(cfg_out[cell_index(5, 3)] && cfg_out == exp_cfg, "R3", $sformatf("%h", cfg_out), $sformatf("%h", exp_cfg));
    read_and_check(exp_cfg, "R8");
    chk(cfg_out == exp_cfg, "R4", $sformatf("%h", cfg_out), $sformatf("%h", exp_cfg));

    for (int it = 0; it < 8; it++) begin
      v = rand_vec();
      shift_vec(v);
      chk(cfg_out == exp_cfg, "R4", $sformatf("%h", cfg_out), $sformatf("%h", exp_cfg));
      do_load();
      exp_cfg = v;
      chk(cfg_out == exp_cfg, "R3", $sformatf("%h", cfg_out), $sformatf("%h", exp_cfg));
      idx = $urandom_range(CELLS - 1);
      which = $urandom_range(2);
      flip(which, idx);
      chk(cfg_out == exp_cfg, "R5", $sformatf("%h", cfg_out), $sformatf("%h", exp_cfg));
      chk(!err, "R7", $sformatf("%b", err), "0");
      step();
      chk(err, "R7", $sformatf("%b", err), "1");
      step();
      chk(!err, "R7", $sformatf("%b", err), "0");
      read_and_check(exp_cfg, "R8");
    end

    idx = cell_index(7, 6);
    flip(1, idx);
    step();
    flip(2, idx);
    chk(cfg_out[idx] == exp_cfg[idx], "R6", $sformatf("%b", cfg_out[idx]), $sformatf("%b", exp_cfg[idx]));
    step();
    flip(0, idx);
    step();
    chk(cfg_out == exp_cfg, "R6", $sformatf("%h", cfg_out), $sformatf("%h", exp_cfg));

    v = rand_vec();
    shift_vec(v);
    load = 1;
    shift_en = 1;
    sin = 1;
    step();
    load = 0;
    shift_en = 0;
    sin = 0;
    chk(cfg_out == v, "R9", $sformatf("%h", cfg_out), $sformatf("%h", v));
    chk(sout == v[CELLS-2], "R9", $sformatf("%b", sout), $sformatf("%b", v[CELLS-2]));
    exp_cfg = v;
    readback = 1;
    shift_en = 1;
    step();
    readback = 0;
    shift_en = 0;
    chk(sout == exp_cfg[CELLS-1], "R9", $sformatf("%b", sout), $sformatf("%b", exp_cfg[CELLS-1]));

    rst = 1;
    step();
    rst = 0;
    chk(cfg_out == '0 && !err && !sout, "R1", $sformatf("cfg %h err %b", cfg_out, err), "all zero");

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule